// File: doc/BRIEF.md
# Receive Character-to-Word Repacker with Address Filter

This block sits after the receive character decoder. It rebuilds 10-bit source words from a stream of decoded 8-bit characters and passes them to the write port of a receive FIFO. Bits are collected least significant first in a small shift accumulator, and a word is released as soon as ten bits are present. Five characters therefore yield four words, and a word may span two characters.

Command characters mark frame boundaries and announce special fields. Any command character discards the partial bits that are still waiting. One header code says that the next 10 bits form a station address. That address is compared with a 10-bit local address register, either as a set of ten domain bits (multicast) or as one exact value out of 1024 (unicast). A failed match drops the words that follow until the next address field. A second header code says that the next 10 bits form an extended command code out of 1024. That code is delivered to the FIFO with a command strobe.

Packing needs a FIFO between the block and its reader, so the block runs only while `enable` is high. Pulling `enable` low, which is the FIFO-bypass configuration, stops and flushes it. The FIFO is seen as a ready/valid sink. When the sink is not ready, the block holds its output and stalls the character input.

Top module: `rx_repack_filter`

## Requirements
- R1: Data characters are packed least significant bit first into a continuous bit stream, and data word i is stream bits 10i to 10i+9. Five characters give four words, and bits of an incomplete word stay pending.
- R2: A character with `chIsCmd`=1 is never emitted as data. It discards all pending partial bits, so the next data character starts a new word at bit 0.
- R3: After command code 0x03, the next 10 stream bits (the first character, plus bits 1:0 of the second character) form an extended command code. This code is emitted with `wordIsCmd`=1. The remaining bits of the second character are discarded.
- R4: After command code 0x02, the next 10 stream bits, taken the same way, form an address. When `multicastMode`=0, `addrMatch` becomes 1 only if the address equals `serialAddr`. When `multicastMode`=1, `addrMatch` becomes 1 if the address and `serialAddr` share at least one set bit. The address is not emitted.
- R5: While `addrMatch`=0, data words and extended command words are dropped and are not written to the sink.
- R6: While `wordValid`=1 and `wordReady`=0, the values of `wordValid`, `wordData` and `wordIsCmd` are held. No word is lost or duplicated under any ready pattern.
- R7: While `enable`=0, `chReady` is 0. From the next cycle onward `wordValid` is 0, the pending bits are cleared and `addrMatch` is 1.
- R8: After reset, `wordValid`=0 and `addrMatch`=1, and `chReady` equals `enable`.
- R9: Data words are emitted with `wordIsCmd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Repack mode on; low means FIFO bypassed, block idle and flushed |
| multicastMode | input | 1 | 1: domain-mask match, 0: exact match |
| serialAddr | input | 10 | Local address register |
| chValid | input | 1 | Input character valid |
| chReady | output | 1 | Input character accepted this cycle when high with chValid |
| chData | input | 8 | Decoded character |
| chIsCmd | input | 1 | Character is a command (0x02 address header, 0x03 extended command header, others realign only) |
| wordValid | output | 1 | Output word valid toward FIFO |
| wordReady | input | 1 | FIFO can accept a word |
| wordData | output | 10 | Output word |
| wordIsCmd | output | 1 | Output word is an extended command code |
| addrMatch | output | 1 | Current address filter result |

## Verification
The packing is tried with frames of 5, 10, 13 and 20 characters drawn from several arithmetic seeds. Each frame is run once with a sink that is always ready and once with a sink that is ready one cycle in three. Frame lengths that are not multiples of five separate correct handling of the leftover bits from misalignment, and the stalled runs separate correct holding from lost or repeated words. A stream broken in mid-word by a command character shows whether the discarded bits leak into the next frame. The address filter is swept over all 1024 received addresses in both match modes, which separates a mask test from an equality test. Command codes at 0, 1023 and spaced values in between, with garbage in the unused upper bits, show that exactly 10 bits are taken.

// File: rtl/rx_repack_pkg.sv
package rx_repack_pkg;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_CMD  = 2'd2
  } wordKind_e;

  typedef struct packed {
    logic appendChar;
    logic extractWord;
    logic clearAcc;
    logic loadOut;
    logic loadIsCmd;
    logic clearOut;
  } repackStrobes_t;

endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] rxAddr,
  input  logic [WORD_W-1:0] ownAddr,
  input  logic              multicastMode,
  output logic              hit
);

  logic [WORD_W-1:0] domainHit;
  logic [WORD_W-1:0] bitEqual;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign domainHit[i] = rxAddr[i] & ownAddr[i];
    assign bitEqual[i]  = ~(rxAddr[i] ^ ownAddr[i]);
  end

  assign hit = multicastMode ? (|domainHit) : (&bitEqual);

endmodule

// File: rtl/rx_repack_datapath.sv
module rx_repack_datapath
  import rx_repack_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int WORD_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  repackStrobes_t      strobes,
  input  logic [CHAR_W-1:0]   chData,
  input  logic                wordReady,
  output logic                wordAvail,
  output logic [WORD_W-1:0]   pendWord,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord,
  output logic                outIsCmd
);

  localparam int ACC_W = WORD_W + CHAR_W;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CHAR_CNT = CNT_W'(CHAR_W);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(ACC_W);

  logic [ACC_W-1:0] acc, accShift, accNext;
  logic [CNT_W-1:0] cnt, cntShift, cntNext;

  always_comb begin
    accShift = strobes.extractWord ? (acc >> WORD_W) : acc;
    cntShift = strobes.extractWord ? (cnt - WORD_CNT) : cnt;
    accNext  = accShift;
    cntNext  = cntShift;
    if (strobes.clearAcc) begin
      accNext = '0;
      cntNext = '0;
    end else if (strobes.appendChar) begin
      accNext = accShift | (ACC_W'(chData) << cntShift);
      cntNext = cntShift + CHAR_CNT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= accNext;
      cnt <= cntNext;
    end
  end

  assign wordAvail = (cnt >= WORD_CNT);
  assign pendWord  = acc[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outIsCmd <= 1'b0;
    end else if (strobes.clearOut) begin
      outValid <= 1'b0;
    end else if (strobes.loadOut) begin
      outValid <= 1'b1;
      outWord  <= pendWord;
      outIsCmd <= strobes.loadIsCmd;
    end else if (wordReady) begin
      outValid <= 1'b0;
    end
  end

  // R1: pending bit count never exceeds accumulator capacity
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= MAX_CNT);

  // R6: a word refused by the sink is held unchanged
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !wordReady && !strobes.clearOut) |=>
      (outValid && $stable(outWord) && $stable(outIsCmd)));

endmodule

// File: rtl/rx_repack_control.sv
module rx_repack_control
  import rx_repack_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int WORD_W = 10,
  parameter logic [CHAR_W-1:0] ADDR_HDR = 8'h02,
  parameter logic [CHAR_W-1:0] CMD_HDR  = 8'h03
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                multicastMode,
  input  logic [WORD_W-1:0]   serialAddr,
  input  logic                chValid,
  input  logic [CHAR_W-1:0]   chData,
  input  logic                chIsCmd,
  input  logic                wordAvail,
  input  logic [WORD_W-1:0]   pendWord,
  input  logic                outValid,
  input  logic                wordReady,
  output logic                chReady,
  output repackStrobes_t      strobes,
  output logic                addrMatch
);

  wordKind_e kind, kindNext;
  logic      accepted, acceptedNext;
  logic      addrHit, slotFree, needsSlot, extract, take, kindIsData;

  rx_addr_match #(.WORD_W(WORD_W)) addrMatch_i (
    .rxAddr       (pendWord),
    .ownAddr      (serialAddr),
    .multicastMode(multicastMode),
    .hit          (addrHit)
  );

  always_comb begin
    kindIsData = (kind == KIND_DATA);
    slotFree   = !outValid || wordReady;
    needsSlot  = (kind != KIND_ADDR) && accepted;
    extract    = enable && wordAvail && (!needsSlot || slotFree);
    chReady    = enable && (!wordAvail || (extract && kindIsData));
    take       = chValid && chReady;

    strobes.extractWord = extract;
    strobes.loadOut     = extract && needsSlot;
    strobes.loadIsCmd   = (kind == KIND_CMD);
    strobes.appendChar  = take && !chIsCmd;
    strobes.clearAcc    = !enable || (take && chIsCmd) || (extract && !kindIsData);
    strobes.clearOut    = !enable;

    kindNext     = kind;
    acceptedNext = accepted;
    if (!enable) begin
      kindNext     = KIND_DATA;
      acceptedNext = 1'b1;
    end else if (take && chIsCmd) begin
      if (chData == ADDR_HDR)     kindNext = KIND_ADDR;
      else if (chData == CMD_HDR) kindNext = KIND_CMD;
      else                        kindNext = KIND_DATA;
    end else if (extract && !kindIsData) begin
      kindNext = KIND_DATA;
      if (kind == KIND_ADDR) acceptedNext = addrHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind     <= KIND_DATA;
      accepted <= 1'b1;
    end else begin
      kind     <= kindNext;
      accepted <= acceptedNext;
    end
  end

  assign addrMatch = accepted;

  // R4: multicast with no shared domain bit rejects
  a_r4_mcast_miss: assert property (@(posedge clk) disable iff (!rstN)
    (extract && kind == KIND_ADDR && multicastMode && ((pendWord & serialAddr) == '0))
      |=> !addrMatch);

  // R4: unicast exact address accepts
  a_r4_ucast_hit: assert property (@(posedge clk) disable iff (!rstN)
    (extract && kind == KIND_ADDR && !multicastMode && (pendWord == serialAddr))
      |=> addrMatch);

  // R5: a new output word only appears while the filter accepts
  a_r5_filtered_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(accepted));

  // R7: disabling empties the output register
  a_r7_disable_flush: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!outValid && addrMatch));

endmodule

// File: rtl/rx_repack_filter.sv
module rx_repack_filter
  import rx_repack_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int WORD_W = 10,
  parameter logic [CHAR_W-1:0] ADDR_HDR = 8'h02,
  parameter logic [CHAR_W-1:0] CMD_HDR  = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              multicastMode,
  input  logic [WORD_W-1:0] serialAddr,
  input  logic              chValid,
  output logic              chReady,
  input  logic [CHAR_W-1:0] chData,
  input  logic              chIsCmd,
  output logic              wordValid,
  input  logic              wordReady,
  output logic [WORD_W-1:0] wordData,
  output logic              wordIsCmd,
  output logic              addrMatch
);

  repackStrobes_t    strobes;
  logic              wordAvail;
  logic [WORD_W-1:0] pendWord;

  rx_repack_control #(
    .CHAR_W(CHAR_W), .WORD_W(WORD_W), .ADDR_HDR(ADDR_HDR), .CMD_HDR(CMD_HDR)
  ) control_i (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .multicastMode(multicastMode),
    .serialAddr   (serialAddr),
    .chValid      (chValid),
    .chData       (chData),
    .chIsCmd      (chIsCmd),
    .wordAvail    (wordAvail),
    .pendWord     (pendWord),
    .outValid     (wordValid),
    .wordReady    (wordReady),
    .chReady      (chReady),
    .strobes      (strobes),
    .addrMatch    (addrMatch)
  );

  rx_repack_datapath #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .chData   (chData),
    .wordReady(wordReady),
    .wordAvail(wordAvail),
    .pendWord (pendWord),
    .outValid (wordValid),
    .outWord  (wordData),
    .outIsCmd (wordIsCmd)
  );

endmodule

// File: tb/rx_repack_filter_tb_top.sv
module rx_repack_filter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       multicastMode = 1'b0;
  logic [9:0] serialAddr = '0;
  logic       chValid = 1'b0;
  logic       chReady;
  logic [7:0] chData = '0;
  logic       chIsCmd = 1'b0;
  logic       wordValid;
  logic       wordReady = 1'b1;
  logic [9:0] wordData;
  logic       wordIsCmd;
  logic       addrMatch;

  int nChecks = 0;
  int nFails  = 0;
  int stallMode = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [10:0] gotQ[$];
  logic        prevValid = 1'b0, prevReady = 1'b0;
  logic [10:0] prevWord = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_repack_filter dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .multicastMode(multicastMode),
    .serialAddr(serialAddr), .chValid(chValid), .chReady(chReady),
    .chData(chData), .chIsCmd(chIsCmd), .wordValid(wordValid),
    .wordReady(wordReady), .wordData(wordData), .wordIsCmd(wordIsCmd),
    .addrMatch(addrMatch)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // sink model: sets ready, records transfers, checks hold under stall (R6)
  always @(negedge clk) begin
    cyc++;
    if (rstN && enable && prevValid && !prevReady) begin
      check("R6 hold valid", {31'd0, wordValid}, 32'd1);
      check("R6 hold data", {21'd0, wordIsCmd, wordData}, {21'd0, prevWord});
    end
    wordReady = (stallMode == 0) ? 1'b1 : (cyc % 3 == 0);
    if (wordValid && wordReady) gotQ.push_back({wordIsCmd, wordData});
    prevValid = wordValid;
    prevReady = wordReady;
    prevWord  = {wordIsCmd, wordData};
  end

  function automatic logic [7:0] charVal(input int base, input int k);
    return 8'((base * 37 + k * 73 + 5) & 255);
  endfunction

  function automatic logic [9:0] expWord(input int base, input int i);
    logic [9:0] w;
    logic [7:0] c;
    for (int b = 0; b < 10; b++) begin
      c = charVal(base, (10 * i + b) / 8);
      w[b] = c[(10 * i + b) % 8];
    end
    return w;
  endfunction

  task automatic sendChar(input logic cmd, input logic [7:0] d);
    @(negedge clk);
    chValid = 1'b1; chIsCmd = cmd; chData = d;
    #(CLK_PERIOD/4);
    while (!chReady) begin @(negedge clk); #(CLK_PERIOD/4); end
    @(posedge clk); #1;
    chValid = 1'b0;
  endtask

  task automatic sendData(input int base, input int n);
    for (int k = 0; k < n; k++) sendChar(1'b0, charVal(base, k));
  endtask

  task automatic sendField(input logic [7:0] hdr, input logic [9:0] v);
    sendChar(1'b1, hdr);
    sendChar(1'b0, v[7:0]);
    sendChar(1'b0, {6'b101101, v[9:8]});
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic compareSeg(input string req, input int base, input int nExp, input int off);
    for (int i = 0; i < nExp; i++) begin
      if (off + i < gotQ.size())
        check(req, {21'd0, gotQ[off + i]}, {21'd0, 1'b0, expWord(base, i)});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int sizes[4] = '{5, 10, 13, 20};
    logic [9:0] a;
    // R8 reset state
    repeat (4) @(negedge clk);
    check("R8 wordValid", {31'd0, wordValid}, 32'd0);
    check("R8 addrMatch", {31'd0, addrMatch}, 32'd1);
    check("R8 chReady", {31'd0, chReady}, 32'd1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 packing and R6 back-pressure sweep, R9 data flag
    for (int sm = 0; sm < 2; sm++) begin
      stallMode = sm;
      for (int base = 0; base < 8; base++) begin
        for (int s = 0; s < 4; s++) begin
          gotQ.delete();
          sendChar(1'b1, 8'h01);
          sendData(base, sizes[s]);
          drain();
          check(sm ? "R6 word count" : "R1 word count", gotQ.size(), (sizes[s] * 8) / 10);
          compareSeg("R1 R9 word", base, (sizes[s] * 8) / 10, 0);
        end
      end
    end
    stallMode = 0;

    // R2 realign on command characters mid-word
    for (int v = 0; v < 2; v++) begin
      gotQ.delete();
      sendChar(1'b1, 8'h01);
      sendData(11 + v, 7);
      sendChar(1'b1, v ? 8'h7E : 8'h01);
      sendData(21 + v, 5);
      drain();
      check("R2 word count", gotQ.size(), 9);
      compareSeg("R2 first frame", 11 + v, 5, 0);
      compareSeg("R2 realigned frame", 21 + v, 4, 5);
    end

    // R3 extended command codes, followed by aligned data
    for (int c = 0; c < 1024; c += 93) begin
      for (int e = 0; e < 2; e++) begin
        a = e ? 10'(1023 - c) : 10'(c);
        gotQ.delete();
        sendField(8'h03, a);
        sendData(c, 5);
        drain();
        check("R3 count", gotQ.size(), 5);
        if (gotQ.size() > 0) check("R3 command word", {21'd0, gotQ[0]}, {21'd0, 1'b1, a});
        compareSeg("R3 R9 data after command", c, 4, 1);
      end
    end

    // R4 unicast exhaustive
    multicastMode = 1'b0; serialAddr = 10'h2C9;
    for (int i = 0; i < 1024; i++) begin
      sendField(8'h02, 10'(i));
      repeat (3) @(negedge clk);
      check("R4 unicast", {31'd0, addrMatch}, {31'd0, (10'(i) == serialAddr)});
    end
    // R4 multicast exhaustive
    multicastMode = 1'b1; serialAddr = 10'b0100100001;
    for (int i = 0; i < 1024; i++) begin
      sendField(8'h02, 10'(i));
      repeat (3) @(negedge clk);
      check("R4 multicast", {31'd0, addrMatch}, {31'd0, |(10'(i) & serialAddr)});
    end

    // R5 filtered traffic dropped, accepted traffic passes
    gotQ.delete();
    sendField(8'h02, 10'b1011011110);
    sendData(3, 5);
    sendField(8'h03, 10'h155);
    drain();
    check("R5 addrMatch low", {31'd0, addrMatch}, 32'd0);
    check("R5 dropped count", gotQ.size(), 0);
    sendField(8'h02, 10'b0000000001);
    sendData(4, 5);
    drain();
    check("R5 accepted count", gotQ.size(), 4);
    compareSeg("R5 accepted data", 4, 4, 0);

    // R7 disable: no intake, flush, filter reset, realign
    sendField(8'h02, 10'b0000000010);
    repeat (3) @(negedge clk);
    check("R7 pre addrMatch", {31'd0, addrMatch}, 32'd0);
    gotQ.delete();
    sendField(8'h02, 10'b0000000001);
    sendData(6, 3);
    drain();
    check("R7 pre count", gotQ.size(), 2);
    sendField(8'h02, 10'b0000000010);
    @(negedge clk);
    enable = 1'b0; chValid = 1'b1; chIsCmd = 1'b0; chData = 8'hA5;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7 chReady", {31'd0, chReady}, 32'd0);
      check("R7 wordValid", {31'd0, wordValid}, 32'd0);
      check("R7 addrMatch", {31'd0, addrMatch}, 32'd1);
    end
    chValid = 1'b0;
    enable = 1'b1;
    gotQ.delete();
    sendData(7, 5);
    drain();
    check("R7 realigned count", gotQ.size(), 4);
    compareSeg("R7 realigned data", 7, 4, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule